// File: doc/BRIEF.md
# Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit data word and produces the shifted word, a carry flag and a flag that marks whether the requested operation was legal. The block supports logical left, logical right, arithmetic right, rotate right and a one-bit rotate that passes through the carry. The caller describes each request in one of three ways, selected by `in_form`:

- An instruction-style immediate: a 2-bit kind and a 5-bit amount. Some zero amounts in this form carry special meanings.
- A register amount: a 2-bit kind and an 8-bit amount.
- A raw operation: a 3-bit operation code and the 8-bit amount.

A request is accepted on any cycle where `in_stb` is high. The results appear one cycle later, together with a single-cycle `res_stb` pulse. There is no back-pressure. The block accepts a new request on every cycle, and the consumer must take each result in the cycle where `res_stb` is high. Between strobes the result outputs keep their last value. The block does not pull operand fields out of a full instruction word, and it does not write flags back.

Top module: `barrel_shift_unit`

## Requirements
- R1: `res_stb` is high exactly one cycle after a cycle with `in_stb` high, and low otherwise. `res_data`, `res_cout` and `res_ok` change only in that cycle and otherwise hold their value.
- R2: The 2-bit kind is encoded as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. In register form (`in_form`=1) the kind is applied with the 8-bit `in_reg_amt`.
- R3: In immediate form (`in_form`=0), kind 1 or kind 2 with `in_imm_amt`=0 shifts by 32.
- R4: In immediate form, kind 3 with `in_imm_amt`=0 performs the extended rotate by one. The result is `in_cin` in bit 31 above input bits 31..1, and the carry-out is input bit 0.
- R5: In raw form (`in_form`=2), `in_xop` uses codes 0..3 as in R2 and code 4 as the extended rotate. Code 4 with any amount other than 1 is illegal. Codes 5..7, and `in_form`=3, are always illegal. An illegal request gives `res_ok`=0, `res_data`=0 and `res_cout`=0.
- R6: A legal request with an effective amount of 0 returns the data unchanged, with the carry-out equal to `in_cin`.
- R7: A logical left shift by n ≥ 1 gives a carry-out of input bit (32 − n) when n ≤ 32, and 0 when n > 32. The result is 0 when n ≥ 32.
- R8: A logical right shift by n ≥ 1 gives a carry-out of input bit (n − 1) when n ≤ 32, and 0 when n > 32. The result is 0 when n ≥ 32.
- R9: An arithmetic right shift by n from 1 to 31 fills with the sign bit and carries out input bit (n − 1). When n ≥ 32, every result bit equals the sign bit and the carry-out equals the sign bit.
- R10: A rotate right by n ≥ 1 rotates by n modulo 32, and the carry-out is bit 31 of the rotated result.
- R11: While reset is held, `res_stb`, `res_data`, `res_cout` and `res_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Request strobe |
| in_form | input | 2 | 0 immediate, 1 register amount, 2 raw op, 3 illegal |
| in_kind | input | 2 | Shift kind for forms 0 and 1 |
| in_imm_amt | input | 5 | Immediate amount |
| in_reg_amt | input | 8 | Amount for forms 1 and 2 |
| in_xop | input | 3 | Raw operation code for form 2 |
| in_data | input | 32 | Word to shift |
| in_cin | input | 1 | Carry-in flag |
| res_stb | output | 1 | Result strobe, one cycle after `in_stb` |
| res_data | output | 32 | Shifted word |
| res_cout | output | 1 | Carry-out flag |
| res_ok | output | 1 | Request was legal |

## Verification
The hardest region to reach is the boundary of the amount range, around 31, 32 and 33. There the carry source moves off the end of the word and the fill rules change for each kind. Uniform random 8-bit amounts land there only rarely. Directed sweeps therefore run every kind over amounts 0 to 40 in register form. Further sweeps cover every immediate encoding, every raw code over small amounts, and the illegal forms. Random words and carries mixed among these sweeps expose any wrong carry tap.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  // Internal operation after decoding.
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4,
    SH_BAD = 3'd7
  } sh_op_e;

  // How a request describes its operation.
  typedef enum logic [1:0] {
    FORM_IMM  = 2'd0,
    FORM_REG  = 2'd1,
    FORM_RAW  = 2'd2,
    FORM_NONE = 2'd3
  } sh_form_e;
endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 5,
  parameter int AW = 8
) (
  input  logic [1:0]    form,
  input  logic [1:0]    kind,
  input  logic [IW-1:0] imm_amt,
  input  logic [AW-1:0] reg_amt,
  input  logic [2:0]    xop,
  output sh_op_e        op,
  output logic [AW-1:0] amt
);
  localparam logic [AW-1:0] FULL = AW'(W);

  logic imm_zero;
  assign imm_zero = (imm_amt == '0);

  always_comb begin
    op  = SH_BAD;
    amt = reg_amt;
    unique case (sh_form_e'(form))
      FORM_IMM: begin
        amt = AW'(imm_amt);
        unique case (kind)
          2'd0: op = SH_LSL;
          2'd1: begin op = SH_LSR; if (imm_zero) amt = FULL; end
          2'd2: begin op = SH_ASR; if (imm_zero) amt = FULL; end
          default: begin
            if (imm_zero) begin
              op  = SH_RRX;
              amt = AW'(1);
            end else begin
              op = SH_ROR;
            end
          end
        endcase
      end
      FORM_REG: op = sh_op_e'({1'b0, kind});
      FORM_RAW: op = sh_op_e'(xop);
      default:  op = SH_BAD;
    endcase
  end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
#(
  parameter int W  = 32,   // power of two
  parameter int AW = 8
) (
  input  logic [W-1:0]  data,
  input  sh_op_e        op,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          ok
);
  localparam int SW = $clog2(W);

  // Left shifts run through the same right rotator on bit-reversed data.
  logic [W-1:0] data_rev, src;
  for (genvar i = 0; i < W; i++) begin : g_rev_in
    assign data_rev[i] = data[W-1-i];
  end
  assign src = (op == SH_LSL) ? data_rev : data;

  // Logarithmic rotate-right by amt mod W.
  logic [W-1:0] stg [SW+1];
  assign stg[0] = src;
  for (genvar k = 0; k < SW; k++) begin : g_rot
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][D-1:0], stg[k][W-1:D]} : stg[k];
  end

  logic [W-1:0] rot, keep, masked, masked_rev, pick;
  logic         tap, sign, beyond;
  assign rot    = stg[SW];
  assign keep   = {W{1'b1}} >> amt;
  assign masked = rot & keep;
  for (genvar i = 0; i < W; i++) begin : g_rev_out
    assign masked_rev[i] = masked[W-1-i];
  end
  // One-hot tap at bit amt-1; empty when amt is 0 or beyond W.
  assign pick   = W'(1) << (amt - AW'(1));
  assign tap    = |(src & pick);
  assign sign   = data[W-1];
  assign beyond = (amt > AW'(W));

  always_comb begin
    ok   = 1'b1;
    res  = data;
    cout = cin;
    if (op > SH_RRX || (op == SH_RRX && amt != AW'(1))) begin
      ok   = 1'b0;
      res  = '0;
      cout = 1'b0;
    end else if (amt != '0) begin
      unique case (op)
        SH_LSL: begin res = masked_rev; cout = tap; end
        SH_LSR: begin res = masked;     cout = tap; end
        SH_ASR: begin
          res  = masked | ({W{sign}} & ~keep);
          cout = beyond ? sign : tap;
        end
        SH_ROR: begin res = rot; cout = rot[W-1]; end
        default: begin
          res  = {cin, data[W-1:1]};
          cout = data[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 5,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_stb,
  input  logic [1:0]    in_form,
  input  logic [1:0]    in_kind,
  input  logic [IW-1:0] in_imm_amt,
  input  logic [AW-1:0] in_reg_amt,
  input  logic [2:0]    in_xop,
  input  logic [W-1:0]  in_data,
  input  logic          in_cin,
  output logic          res_stb,
  output logic [W-1:0]  res_data,
  output logic          res_cout,
  output logic          res_ok
);
  sh_op_e        op;
  logic [AW-1:0] amt;
  logic [W-1:0]  nxt_data;
  logic          nxt_cout, nxt_ok;

  bsh_decode #(.W(W), .IW(IW), .AW(AW)) u_dec (
    .form(in_form), .kind(in_kind), .imm_amt(in_imm_amt),
    .reg_amt(in_reg_amt), .xop(in_xop), .op(op), .amt(amt)
  );

  bsh_core #(.W(W), .AW(AW)) u_core (
    .data(in_data), .op(op), .amt(amt), .cin(in_cin),
    .res(nxt_data), .cout(nxt_cout), .ok(nxt_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_stb  <= 1'b0;
      res_data <= '0;
      res_cout <= 1'b0;
      res_ok   <= 1'b0;
    end else begin
      res_stb <= in_stb;
      if (in_stb) begin
        res_data <= nxt_data;
        res_cout <= nxt_cout;
        res_ok   <= nxt_ok;
      end
    end
  end
endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
  parameter int W  = 32,
  parameter int IW = 5,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_stb,
  input logic [1:0]    in_form,
  input logic [1:0]    in_kind,
  input logic [IW-1:0] in_imm_amt,
  input logic [AW-1:0] in_reg_amt,
  input logic [2:0]    in_xop,
  input logic [W-1:0]  in_data,
  input logic          in_cin,
  input logic          res_stb,
  input logic [W-1:0]  res_data,
  input logic          res_cout,
  input logic          res_ok
);
  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> res_stb);
  assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> (!res_stb && $stable(res_data) && $stable(res_cout) && $stable(res_ok)));

  assert_imm_zero_is_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && in_form == 2'd0 && in_kind == 2'd1 && in_imm_amt == '0)
    |=> (res_ok && res_data == '0 && res_cout == $past(in_data[W-1])));

  assert_imm_extended_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && in_form == 2'd0 && in_kind == 2'd3 && in_imm_amt == '0)
    |=> (res_ok && res_data == {$past(in_cin), $past(in_data[W-1:1])}
         && res_cout == $past(in_data[0])));

  assert_illegal_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && (in_form == 2'd3 || (in_form == 2'd2 && (in_xop > 3'd4
      || (in_xop == 3'd4 && in_reg_amt != AW'(1))))))
    |=> (!res_ok && res_data == '0 && !res_cout));

  assert_zero_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && in_form == 2'd1 && in_reg_amt == '0)
    |=> (res_ok && res_data == $past(in_data) && res_cout == $past(in_cin)));

  assert_sign_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && in_form == 2'd1 && in_kind == 2'd2 && in_reg_amt >= AW'(W))
    |=> (res_data == {W{$past(in_data[W-1])}} && res_cout == $past(in_data[W-1])));
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.W(W), .IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_form(in_form),
  .in_kind(in_kind), .in_imm_amt(in_imm_amt), .in_reg_amt(in_reg_amt),
  .in_xop(in_xop), .in_data(in_data), .in_cin(in_cin), .res_stb(res_stb),
  .res_data(res_data), .res_cout(res_cout), .res_ok(res_ok)
);

// File: tb/barrel_shift_unit_tb.sv
module barrel_shift_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_stb = 1'b0;
  logic [1:0]  in_form = '0;
  logic [1:0]  in_kind = '0;
  logic [4:0]  in_imm_amt = '0;
  logic [7:0]  in_reg_amt = '0;
  logic [2:0]  in_xop = '0;
  logic [31:0] in_data = '0;
  logic        in_cin = 1'b0;
  logic        res_stb, res_cout, res_ok;
  logic [31:0] res_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [33:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_form(in_form),
    .in_kind(in_kind), .in_imm_amt(in_imm_amt), .in_reg_amt(in_reg_amt),
    .in_xop(in_xop), .in_data(in_data), .in_cin(in_cin), .res_stb(res_stb),
    .res_data(res_data), .res_cout(res_cout), .res_ok(res_ok)
  );

  // Returns {ok, cout, data}.
  function automatic logic [33:0] ref_model(input logic [1:0] form, input logic [1:0] kind,
      input logic [4:0] imm, input logic [7:0] ramt, input logic [2:0] xop,
      input logic [31:0] d, input logic cin);
    int op, n, m;
    logic [31:0] r;
    logic c;
    case (form)
      2'd0: begin
        op = int'(kind); n = int'(imm);
        if ((kind == 2'd1 || kind == 2'd2) && imm == 5'd0) n = 32;
        if (kind == 2'd3 && imm == 5'd0) begin op = 4; n = 1; end
      end
      2'd1: begin op = int'(kind); n = int'(ramt); end
      2'd2: begin op = int'(xop);  n = int'(ramt); end
      default: begin op = 7; n = 0; end
    endcase
    if (op > 4 || (op == 4 && n != 1)) return {1'b0, 1'b0, 32'h0};
    if (n == 0) return {1'b1, cin, d};
    r = '0; c = 1'b0;
    case (op)
      0: if (n < 32) begin r = d << n; c = d[32-n]; end
         else if (n == 32) c = d[0];
      1: if (n < 32) begin r = d >> n; c = d[n-1]; end
         else if (n == 32) c = d[31];
      2: if (n < 32) begin r = 32'($signed(d) >>> n); c = d[n-1]; end
         else begin r = {32{d[31]}}; c = d[31]; end
      3: begin m = n % 32; r = (d >> m) | (d << (32 - m)); c = r[31]; end
      default: begin r = {cin, d[31:1]}; c = d[0]; end
    endcase
    return {1'b1, c, r};
  endfunction

  task automatic apply(input string tag, input logic [1:0] form, input logic [1:0] kind,
      input logic [4:0] imm, input logic [7:0] ramt, input logic [2:0] xop,
      input logic [31:0] d, input logic cin);
    logic [33:0] exp;
    in_stb = 1'b1; in_form = form; in_kind = kind; in_imm_amt = imm;
    in_reg_amt = ramt; in_xop = xop; in_data = d; in_cin = cin;
    exp = ref_model(form, kind, imm, ramt, xop, d, cin);
    @(negedge clk);
    n_checks++;
    if (res_stb !== 1'b1 || {res_ok, res_cout, res_data} !== exp) begin
      n_fail++;
      $display("FAIL %s form=%0d kind=%0d imm=%0d ramt=%0d xop=%0d d=%h cin=%b: got stb=%b ok=%b c=%b r=%h, expected stb=1 ok=%b c=%b r=%h",
        tag, form, kind, imm, ramt, xop, d, cin, res_stb, res_ok, res_cout, res_data,
        exp[33], exp[32], exp[31:0]);
    end
    last_exp = exp;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    n_checks++;
    if (res_stb !== 1'b0 || res_data !== '0 || res_cout !== 1'b0 || res_ok !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got stb=%b r=%h c=%b ok=%b, expected all 0",
        res_stb, res_data, res_cout, res_ok);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3: immediate zero means 32 for logical and arithmetic right
    apply("R3", 2'd0, 2'd1, 5'd0, 8'd0, 3'd0, 32'h8000_0001, 1'b0);
    apply("R3", 2'd0, 2'd2, 5'd0, 8'd0, 3'd0, 32'h8765_4321, 1'b0);
    apply("R3", 2'd0, 2'd2, 5'd0, 8'd0, 3'd0, 32'h1234_5678, 1'b1);
    // R4: immediate extended rotate
    apply("R4", 2'd0, 2'd3, 5'd0, 8'd0, 3'd0, 32'h0000_0001, 1'b1);
    apply("R4", 2'd0, 2'd3, 5'd0, 8'd0, 3'd0, 32'hFFFF_FFFE, 1'b0);
    // R6: zero amounts
    for (int k = 0; k < 4; k++) begin
      apply("R6", 2'd1, 2'(k), 5'd0, 8'd0, 3'd0, $urandom, 1'b1);
      apply("R6", 2'd1, 2'(k), 5'd0, 8'd0, 3'd0, $urandom, 1'b0);
    end
    apply("R6", 2'd0, 2'd0, 5'd0, 8'd0, 3'd0, 32'hDEAD_BEEF, 1'b1);
    // R5: raw codes, legal and illegal
    for (int x = 0; x < 8; x++)
      for (int a = 0; a < 4; a++)
        apply("R5", 2'd2, 2'd0, 5'd0, 8'(a), 3'(x), $urandom, 1'($urandom));
    apply("R5", 2'd3, 2'd1, 5'd3, 8'd3, 3'd1, 32'hFFFF_FFFF, 1'b1);
    // R7..R10 sweeps over register amounts 0..40, plus large
    for (int a = 0; a <= 40; a++) begin
      apply("R7",  2'd1, 2'd0, 5'd0, 8'(a), 3'd0, $urandom, 1'($urandom));
      apply("R8",  2'd1, 2'd1, 5'd0, 8'(a), 3'd0, $urandom, 1'($urandom));
      apply("R9",  2'd1, 2'd2, 5'd0, 8'(a), 3'd0, $urandom | 32'h8000_0000, 1'($urandom));
      apply("R9",  2'd1, 2'd2, 5'd0, 8'(a), 3'd0, $urandom & 32'h7FFF_FFFF, 1'($urandom));
      apply("R10", 2'd1, 2'd3, 5'd0, 8'(a), 3'd0, $urandom, 1'($urandom));
    end
    apply("R9",  2'd1, 2'd2, 5'd0, 8'd255, 3'd0, 32'h8000_0000, 1'b0);
    apply("R10", 2'd1, 2'd3, 5'd0, 8'd255, 3'd0, 32'h0000_0081, 1'b0);
    // Immediate form over every kind and amount
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        apply("R2", 2'd0, 2'(k), 5'(a), 8'd0, 3'd0, $urandom, 1'($urandom));
    // R2: random mix
    for (int i = 0; i < 2000; i++)
      apply("R2", 2'($urandom), 2'($urandom), 5'($urandom), 8'($urandom % 48),
            3'($urandom), $urandom, 1'($urandom));

    // R1: no strobe, outputs hold
    in_stb = 1'b0; in_data = ~in_data; in_cin = ~in_cin;
    @(negedge clk);
    n_checks++;
    if (res_stb !== 1'b0 || {res_ok, res_cout, res_data} !== last_exp) begin
      n_fail++;
      $display("FAIL R1 hold: got stb=%b %h, expected stb=0 %h",
        res_stb, {res_ok, res_cout, res_data}, last_exp);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule